// File: doc/BRIEF.md
# Power-Management Event Interrupt Generator

This block holds the power-management event status and event enable registers and produces the level-sensitive system control interrupt (SCI). Four event classes feed the status register: a free-running power-management timer crossing the midpoint or the end of its range, a power button press, a real-time-clock alarm and a global lock release. Software acknowledges an event by writing a one to its status bit. The interrupt stays high while at least one of those four events is both pending and enabled.

The block also drives a timer-armed indication. It tells the rest of the chip that a timer crossing would be delivered as a new interrupt, because the timer event is enabled and not already pending. Software reaches the two registers through a simple write strobe with a register select, and reads them through a combinational read mux.

Top module: `sci_gen`

## Requirements
- R1: After reset the status register, the enable register, the timer count, the interrupt and the timer-armed output are all zero.
- R2: The timer count (`tmr_count`) increases by one on every clock edge and wraps from all-ones to zero.
- R3: Status bit 0 (timer) is set on the clock edge where the timer's most significant bit changes, in both directions (midpoint and wrap).
- R4: A one-cycle pulse on `ev_glock`, `ev_pwrbtn` or `ev_rtc` sets status bit 5, 8 or 10 respectively on that clock edge. The bit then stays set until software clears it.
- R5: A write with `reg_sel`=0 clears every status bit whose data bit is 1 and leaves the other status bits unchanged.
- R6: If an event arrives in the same cycle as a write that clears its status bit, the bit remains set.
- R7: A write with `reg_sel`=1 loads all 16 enable bits. With `reg_rsel`=1, `reg_rdata` shows the enable register, and with `reg_rsel`=0 it shows the status register.
- R8: `sci` is 1 exactly when status AND enable has a 1 in bit 0, 5, 8 or 10. It changes on the same clock edge as the register update that causes it.
- R9: Status bits other than 0, 5, 8 and 10 always read 0. Enable bits outside those four positions never raise `sci`.
- R10: `tmr_armed` is 1 exactly when enable bit 0 is 1 and status bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 status (write 1 to clear), 1 enable |
| reg_wdata | input | 16 | Write data |
| reg_rsel | input | 1 | Read select: 0 status, 1 enable |
| reg_rdata | output | 16 | Read data of the selected register |
| ev_glock | input | 1 | Global lock release event pulse |
| ev_pwrbtn | input | 1 | Power button event pulse |
| ev_rtc | input | 1 | Real-time-clock alarm event pulse |
| tmr_count | output | TMR_W | Free-running timer value |
| tmr_armed | output | 1 | Timer event enabled and not pending |
| sci | output | 1 | System control interrupt level |

## Verification
The hardest state to reach from the ports is a timer crossing combined with a chosen set of external events and enables. The timer cannot be driven; it only runs. The bench therefore builds the design with an 8-bit timer and lines up each step against `tmr_count`. It waits until just after a crossing, clears the status register, applies every combination of enable pattern and external events, and then waits for the next crossing. The race between an event and its own clear is staged the same way, with both presented in a single cycle.

// File: rtl/sci_gen_pkg.sv
package sci_gen_pkg;
    localparam int REG_W   = 16;
    localparam int BIT_TMR = 0;
    localparam int BIT_GLK = 5;
    localparam int BIT_PWR = 8;
    localparam int BIT_RTC = 10;

    localparam logic [REG_W-1:0] SCI_MASK =
        (REG_W'(1) << BIT_TMR) | (REG_W'(1) << BIT_GLK) |
        (REG_W'(1) << BIT_PWR) | (REG_W'(1) << BIT_RTC);

    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] en;
        logic             sci;
    } evt_state_t;
endpackage

// File: rtl/sci_pm_timer.sv
module sci_pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [TMR_W-1:0] cnt,
    output logic             msb_flip
);
    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + TMR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt      = cnt_q;
    // lower bits all ones: the next increment carries into the MSB
    assign msb_flip = &cnt_q[TMR_W-2:0];

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $past(rst_n) |-> cnt_q == TMR_W'($past(cnt_q) + TMR_W'(1))); // R2
endmodule

// File: rtl/sci_evt_regs.sv
module sci_evt_regs
    import sci_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] evt,
    output logic [REG_W-1:0] sts,
    output logic [REG_W-1:0] en,
    output logic             sci
);
    evt_state_t       st_d, st_q;
    logic [REG_W-1:0] clr;
    logic [REG_W-1:0] sts_nxt;

    assign clr = (wr && !sel) ? wdata : '0;

    // one status cell per bit; only event-backed positions hold state
    for (genvar i = 0; i < REG_W; i++) begin : g_sts
        if (SCI_MASK[i]) begin : g_live
            assign sts_nxt[i] = (st_q.sts[i] & ~clr[i]) | evt[i];
        end else begin : g_tied
            assign sts_nxt[i] = 1'b0;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.sts = sts_nxt;
        if (wr && sel) st_d.en = wdata;
        st_d.sci = |(st_d.sts & st_d.en & SCI_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.sts;
    assign en  = st_q.en;
    assign sci = st_q.sci;

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt[BIT_PWR] |=> st_q.sts[BIT_PWR]); // R6
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sel && wdata[BIT_GLK] && !evt[BIT_GLK]) |=> !st_q.sts[BIT_GLK]); // R5
    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel) |=> st_q.en == $past(wdata)); // R7
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts & ~SCI_MASK) == '0); // R9
endmodule

// File: rtl/sci_gen.sv
module sci_gen
    import sci_gen_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [15:0]      reg_wdata,
    input  logic             reg_rsel,
    output logic [15:0]      reg_rdata,
    input  logic             ev_glock,
    input  logic             ev_pwrbtn,
    input  logic             ev_rtc,
    output logic [TMR_W-1:0] tmr_count,
    output logic             tmr_armed,
    output logic             sci
);
    logic             tmr_flip;
    logic [REG_W-1:0] evt_vec;
    logic [REG_W-1:0] sts, en;

    sci_pm_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (tmr_count),
        .msb_flip (tmr_flip)
    );

    always_comb begin
        evt_vec          = '0;
        evt_vec[BIT_TMR] = tmr_flip;
        evt_vec[BIT_GLK] = ev_glock;
        evt_vec[BIT_PWR] = ev_pwrbtn;
        evt_vec[BIT_RTC] = ev_rtc;
    end

    sci_evt_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .evt   (evt_vec),
        .sts   (sts),
        .en    (en),
        .sci   (sci)
    );

    assign reg_rdata = reg_rsel ? en : sts;
    assign tmr_armed = en[BIT_TMR] & ~sts[BIT_TMR];

    AST_TMR_STS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_flip |=> sts[BIT_TMR]); // R3
    AST_SCI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((en & SCI_MASK) == '0) |-> !sci); // R8
    AST_NO_ARM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_flip |=> !tmr_armed); // R10
endmodule

// File: tb/test_sci_gen.sv
module test_sci_gen;
    localparam int TW = 8;
    localparam logic [15:0] MASK = 16'h0521;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_sel = 1'b0, reg_rsel = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          ev_glock = 1'b0, ev_pwrbtn = 1'b0, ev_rtc = 1'b0;
    logic [TW-1:0] tmr_count;
    logic          tmr_armed, sci;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sci_gen #(.TMR_W(TW)) i_sci_gen (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .ev_glock(ev_glock), .ev_pwrbtn(ev_pwrbtn), .ev_rtc(ev_rtc),
        .tmr_count(tmr_count), .tmr_armed(tmr_armed), .sci(sci)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_tmr(input logic [TW-1:0] v);
        while (tmr_count != v) tick();
    endtask

    task automatic wr(input logic s, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic s, output logic [15:0] v);
        reg_rsel = s;
        #1 v = reg_rdata;
    endtask

    function automatic logic [15:0] spread(input logic [3:0] p);
        return {5'b0, p[3], 1'b0, p[2], 2'b0, p[1], 4'b0, p[0]};
    endfunction

    initial begin
        logic [15:0] v, exp_sts, exp_en;
        logic [TW-1:0] prev;
        repeat (3) tick();
        // R1 reset state
        rd(1'b0, v); chk("R1 sts", v, 0);
        rd(1'b1, v); chk("R1 en", v, 0);
        chk("R1 sci", sci, 0); chk("R1 armed", tmr_armed, 0);
        chk("R1 tmr", tmr_count, 0);
        rst_n = 1'b1;
        tick();
        // R2 increment and wrap
        chk("R2 first", tmr_count, 1);
        for (int k = 0; k < 300; k++) begin
            prev = tmr_count; tick();
            chk("R2 step", tmr_count, TW'(prev + 1));
        end
        // R3 both directions of the MSB
        wait_tmr(8'd130); wr(1'b0, 16'hFFFF);
        rd(1'b0, v); chk("R3 cleared", v, 0);
        wait_tmr(8'd255); rd(1'b0, v); chk("R3 before wrap", v, 0);
        tick(); rd(1'b0, v); chk("R3 wrap sets", v, 16'h0001);
        wr(1'b0, 16'h0001);
        wait_tmr(8'd127); rd(1'b0, v); chk("R3 before mid", v, 0);
        tick(); rd(1'b0, v); chk("R3 mid sets", v, 16'h0001);
        // R7 enable readback, R9 reserved status bits
        wr(1'b1, 16'hFFFF); rd(1'b1, v); chk("R7 en ffff", v, 16'hFFFF);
        wr(1'b1, 16'hA5C3); rd(1'b1, v); chk("R7 en a5c3", v, 16'hA5C3);
        wr(1'b1, 16'h0000);
        wait_tmr(8'd130); wr(1'b0, 16'hFFFF);
        ev_glock = 1; ev_pwrbtn = 1; ev_rtc = 1; tick();
        ev_glock = 0; ev_pwrbtn = 0; ev_rtc = 0;
        rd(1'b0, v); chk("R9 only event bits", v, 16'h0520);
        wr(1'b1, ~MASK); chk("R9 unmasked en no sci", sci, 0);
        // R4 sticky, R5 partial clear
        repeat (5) tick();
        rd(1'b0, v); chk("R4 sticky", v, 16'h0520);
        wr(1'b0, 16'h0020); rd(1'b0, v); chk("R5 clear glk", v, 16'h0500);
        wr(1'b0, 16'h0000); rd(1'b0, v); chk("R5 zero write", v, 16'h0500);
        // R6 event wins over clear
        reg_wr = 1; reg_sel = 0; reg_wdata = 16'h0100; ev_pwrbtn = 1;
        tick();
        reg_wr = 0; reg_wdata = '0; ev_pwrbtn = 0;
        rd(1'b0, v); chk("R6 pwr kept", v, 16'h0500);
        wr(1'b0, 16'h0100); rd(1'b0, v); chk("R6 later clear", v, 16'h0400);
        wr(1'b0, 16'hFFFF);
        // R8/R10 sweep: enable pattern x external events, then timer crossing
        for (int e = 0; e < 16; e++) begin
            for (int x = 0; x < 8; x++) begin
                wait_tmr(8'd130);
                wr(1'b0, 16'hFFFF);
                exp_en = spread(4'(e)) | (((e + x) % 2 == 1) ? ~MASK : 16'h0);
                wr(1'b1, exp_en);
                ev_glock = x[0]; ev_pwrbtn = x[1]; ev_rtc = x[2];
                tick();
                ev_glock = 0; ev_pwrbtn = 0; ev_rtc = 0;
                exp_sts = spread({x[2:0], 1'b0});
                rd(1'b0, v); chk("R4 sweep sts", v, exp_sts);
                chk("R8 sweep sci", sci, |(exp_sts & exp_en & MASK));
                chk("R10 sweep armed", tmr_armed, exp_en[0]);
                wait_tmr(8'd127); tick();
                exp_sts[0] = 1'b1;
                rd(1'b0, v); chk("R3 sweep tmr", v, exp_sts);
                chk("R8 sweep sci tmr", sci, |(exp_sts & exp_en & MASK));
                chk("R10 sweep pend", tmr_armed, 0);
            end
        end
        // R8 clearing drops sci on the same edge
        wr(1'b1, 16'h0001); chk("R8 tmr en", sci, 1);
        wr(1'b0, 16'h0001);
        chk("R8 cleared", sci, 0); chk("R10 rearmed", tmr_armed, 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule